// File: doc/BRIEF.md
# Nine-Bit Serial Command Link Transmitter

This block sends single command or parameter bytes to a display panel controller over a write-only link of three wires: an active-low select line, a serial clock and a serial data line. Each request from the upstream sequencer carries one payload byte and a kind flag. The flag says whether the byte is a command or a parameter. The block wraps them in a nine-bit frame. The kind flag goes first on the wire, so the panel needs no separate command/data pin.

The link runs slowly on purpose. Every phase of a frame lasts one half-period, counted in system clock cycles by the parameter `HALF_CYC`. A half-period of 2 us, which gives a 4 us bit time, is reached by setting `HALF_CYC` to the number of system clocks in 2 us. The default value of 100 is for a 50 MHz clock.

Requests come in on a valid/ready handshake. Ready is high only while the link is idle, so the sequencer applies back-pressure simply by holding valid and its payload until ready is seen. A transfer is taken on the first edge where valid and ready are both high. A one-cycle done pulse marks the end of each frame.

Top module: `panel_cmd_serializer`

## Requirements
- R1: After reset, `lnk_csn`, `lnk_sclk` and `lnk_sdo` are all high, `req_ready` is high, and `busy` and `done` are low.
- R2: Each frame has nine bits. Bit 8 is the kind flag, where `req_is_data` = 0 means a command and 1 means a parameter. Bits 7..0 are `req_byte`. Bits are sent from bit 8 down to bit 0, and the receiver captures each one on the rising edge of `lnk_sclk`.
- R3: `lnk_csn` goes low on the edge that accepts a request. It stays low through exactly nine rising edges of `lnk_sclk`, then returns high.
- R4: The first falling edge of `lnk_sclk` comes exactly `HALF_CYC` cycles after `lnk_csn` falls.
- R5: For each bit, `lnk_sclk` stays low for `HALF_CYC` cycles and then high for `HALF_CYC` cycles. While `lnk_csn` is low, `lnk_sdo` changes only in the cycle in which `lnk_sclk` falls.
- R6: `lnk_csn` rises `HALF_CYC` cycles after the ninth rising edge of `lnk_sclk`, and `lnk_sdo` is high at that point. While the link is idle, all three lines stay high.
- R7: `req_ready` is high only while idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. While a frame is in flight, `req_valid` and the payload inputs have no effect on that frame, and no extra frame is produced.
- R8: `done` is high for exactly one cycle, in the cycle where `lnk_csn` has just returned high, and at no other time.
- R9: `busy` is the inverse of `req_ready`. It is high from the accepting edge until the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Upstream has a transfer ready |
| req_ready | output | 1 | Block is idle and can take a transfer |
| req_is_data | input | 1 | Kind flag: 0 = command, 1 = parameter |
| req_byte | input | 8 | Payload byte |
| busy | output | 1 | A frame is in flight |
| done | output | 1 | One-cycle pulse at frame end |
| lnk_csn | output | 1 | Link select, active low |
| lnk_sclk | output | 1 | Link serial clock, idle high |
| lnk_sdo | output | 1 | Link serial data, idle high |

## Verification
The bench builds the block with `HALF_CYC` = 3 instead of the default of 100. A frame then takes only about sixty cycles, so a dozen frames, back-to-back bursts and payload disturbance during busy all fit comfortably in the run. The short half-period still separates every phase boundary by several cycles. A timing error of one cycle in the settle, low or high phases therefore shows up as a wrong phase length.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_LOW    = 2'd2,
    ST_HIGH   = 2'd3
  } pcs_state_e;

endpackage

// File: rtl/pcs_half_timer.sv
module pcs_half_timer #(
  parameter int HALF_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expire
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign expire = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || expire) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // restart always begins a fresh full half-period (R4)
  assert_restart_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && HALF_CYC > 1) |=> !expire);

endmodule

// File: rtl/pcs_frame_shifter.sv
module pcs_frame_shifter #(
  parameter int FRAME_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_frame,
  input  logic               shift,
  output logic               msb
);
  logic [FRAME_W-1:0] sh;

  assign msb = sh[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '1;
    end else if (load) begin
      sh <= load_frame;
    end else if (shift) begin
      sh <= {sh[FRAME_W-2:0], 1'b1};
    end
  end

endmodule

// File: rtl/pcs_link_ctrl.sv
module pcs_link_ctrl
  import pcs_pkg::*;
#(
  parameter int FRAME_W = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic expire,
  input  logic msb_bit,
  output logic req_ready,
  output logic busy,
  output logic done,
  output logic restart,
  output logic load,
  output logic shift,
  output logic csn,
  output logic sclk,
  output logic sdo
);
  localparam int BW = $clog2(FRAME_W + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W);

  pcs_state_e    st;
  logic [BW-1:0] bit_cnt;
  logic          accept;
  logic          go_low;

  always_comb begin
    req_ready = (st == ST_IDLE);
    busy      = !req_ready;
    accept    = req_valid && req_ready;
    restart   = accept;
    load      = accept;
    go_low    = expire && ((st == ST_SETTLE) ||
                           ((st == ST_HIGH) && (bit_cnt != LAST_BIT)));
    shift     = go_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      csn     <= 1'b1;
      sclk    <= 1'b1;
      sdo     <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            st      <= ST_SETTLE;
            csn     <= 1'b0;
            bit_cnt <= '0;
          end
        end
        ST_LOW: begin
          if (expire) begin
            st   <= ST_HIGH;
            sclk <= 1'b1;
          end
        end
        ST_SETTLE, ST_HIGH: begin
          if (go_low) begin
            st      <= ST_LOW;
            sclk    <= 1'b0;
            sdo     <= msb_bit;
            bit_cnt <= bit_cnt + 1'b1;
          end else if (expire && st == ST_HIGH) begin
            st   <= ST_IDLE;
            csn  <= 1'b1;
            sdo  <= 1'b1;
            done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_bit_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST_BIT);

  assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> !csn);

  assert_sdo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn && sclk && $past(sclk) && !$past(csn)) |-> $stable(sdo));

  assert_idle_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    csn |-> (sclk && sdo));

  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> csn);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csn) |-> done);

endmodule

// File: rtl/panel_cmd_serializer.sv
module panel_cmd_serializer #(
  parameter int HALF_CYC  = 100,
  parameter int PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_is_data,
  input  logic [PAYLOAD_W-1:0] req_byte,
  output logic                 busy,
  output logic                 done,
  output logic                 lnk_csn,
  output logic                 lnk_sclk,
  output logic                 lnk_sdo
);
  localparam int FRAME_W = PAYLOAD_W + 1;

  logic               expire;
  logic               restart;
  logic               load;
  logic               shift;
  logic               msb_bit;
  logic [FRAME_W-1:0] frame;

  // kind flag leads the frame (R2)
  assign frame = {req_is_data, req_byte};

  pcs_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .expire  (expire)
  );

  pcs_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_frame (frame),
    .shift      (shift),
    .msb        (msb_bit)
  );

  pcs_link_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .expire    (expire),
    .msb_bit   (msb_bit),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .restart   (restart),
    .load      (load),
    .shift     (shift),
    .csn       (lnk_csn),
    .sclk      (lnk_sclk),
    .sdo       (lnk_sdo)
  );

  assert_busy_inverse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy != req_ready);

endmodule

// File: tb/test_panel_cmd_serializer.sv
module test_panel_cmd_serializer;
  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_is_data = 1'b0;
  logic [7:0] req_byte = 8'h00;
  logic       req_ready, busy, done, lnk_csn, lnk_sclk, lnk_sdo;

  panel_cmd_serializer #(.HALF_CYC(HALF), .PAYLOAD_W(8)) i_panel_cmd_serializer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_data(req_is_data), .req_byte(req_byte), .busy(busy), .done(done),
    .lnk_csn(lnk_csn), .lnk_sclk(lnk_sclk), .lnk_sdo(lnk_sdo)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [8:0] exp_q[$];
  int sent = 0;
  int frames_seen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // driver: pushes the expected frame when the handshake completes
  task automatic send(input bit d, input logic [7:0] b, input int hold);
    @(negedge clk);
    req_valid   = 1'b1;
    req_is_data = d;
    req_byte    = b;
    while (!req_ready) @(negedge clk);
    exp_q.push_back({d, b});
    sent++;
    @(posedge clk);
    @(negedge clk);
    // R7: disturb inputs while busy; must not alter or add frames
    for (int k = 0; k < hold; k++) begin
      req_is_data = ~d;
      req_byte    = ~b;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  // monitor
  int cyc = 0;
  int last_evt = 0;
  int nbits = 0;
  logic [8:0] acc = '0;
  logic p_csn = 1'b1, p_sclk = 1'b1, p_sdo = 1'b1;
  bit mon_on = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (p_csn && !lnk_csn) begin
        chk(!req_ready && busy, "R9 busy at select", {req_ready, busy}, 2'b01);
        last_evt = cyc; nbits = 0; acc = '0;
      end else if (!p_csn && !lnk_csn) begin
        if (p_sclk && !lnk_sclk) begin
          chk(cyc - last_evt == HALF, nbits == 0 ? "R4 settle" : "R5 high phase",
              cyc - last_evt, HALF);
          last_evt = cyc;
        end
        if (!p_sclk && lnk_sclk) begin
          chk(cyc - last_evt == HALF, "R5 low phase", cyc - last_evt, HALF);
          last_evt = cyc;
          acc = {acc[7:0], lnk_sdo};
          nbits++;
        end
        if (lnk_sdo != p_sdo)
          chk(p_sclk && !lnk_sclk, "R5 sdo change off sclk fall", lnk_sdo, p_sdo);
        if (req_ready || !busy)
          chk(1'b0, "R7 ready during frame", req_ready, 0);
      end else if (!p_csn && lnk_csn) begin
        chk(cyc - last_evt == HALF, "R6 last high phase", cyc - last_evt, HALF);
        chk(nbits == 9, "R3 rising edges per frame", nbits, 9);
        chk(lnk_sdo && lnk_sclk, "R6 park high", {lnk_sclk, lnk_sdo}, 2'b11);
        chk(done, "R8 done at select rise", done, 1);
        frames_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected frame", acc, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(acc == e, "R2 frame content", acc, e);
        end
      end else begin
        if (!(lnk_sclk && lnk_sdo))
          chk(1'b0, "R6 idle levels", {lnk_sclk, lnk_sdo}, 2'b11);
      end
      if (done && !(!p_csn && lnk_csn))
        chk(1'b0, "R8 stray done", done, 0);
      if (busy == req_ready)
        chk(1'b0, "R9 busy inverse", busy, !req_ready);
    end
    p_csn = lnk_csn; p_sclk = lnk_sclk; p_sdo = lnk_sdo;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lnk_csn && lnk_sclk && lnk_sdo, "R1 line levels",
        {lnk_csn, lnk_sclk, lnk_sdo}, 3'b111);
    chk(req_ready && !busy && !done, "R1 handshake state",
        {req_ready, busy, done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    send(1'b0, 8'h01, 0);   // R2 command
    send(1'b1, 8'h00, 0);   // R2 parameter, all zero payload
    send(1'b1, 8'hFF, 0);   // all ones
    send(1'b0, 8'hAA, 25);  // R7 disturbance while busy
    send(1'b1, 8'h55, 40);
    repeat (10) @(negedge clk);
    // back-to-back burst: valid held through done
    send(1'b0, 8'hB6, 0);
    send(1'b1, 8'h52, 0);
    send(1'b1, 8'h83, 0);
    send(1'b0, 8'h29, 0);
    send(1'b0, 8'h80, 0);
    send(1'b1, 8'h7F, 0);

    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    repeat (4 * HALF + 10) @(negedge clk);
    chk(frames_seen == sent, "R7 frame count", frames_seen, sent);
    chk(lnk_csn && lnk_sclk && lnk_sdo && !busy, "R6 final idle",
        {lnk_csn, lnk_sclk, lnk_sdo, busy}, 4'b1110);
    finish_run();
  end

endmodule